// File: doc/BRIEF.md
# Multi-byte register transfer sequencer

This block moves a register value one, two or three bytes wide across a bus that is only 8 bits wide. A caller gives it a base address, a two-bit width code, a direction and a one-cycle start. The block then runs one bus cycle per byte at consecutive addresses.

On a load, each returned byte is placed into a 24-bit result with the lowest address in the least significant byte. Result bytes above the loaded width read as zero. On a store, the block presents the register's bytes on the data-out port, least significant byte first, with the write strobe high.

The block also keeps a record of the last three bytes it loaded. A one-cycle done pulse tells the caller that the result is ready or that the store has finished.

Top module: `mbyte_xfer`

## Requirements
- R1: The width code sets the number of bus cycles: 2'b00 gives 1, 2'b01 gives 2, 2'b10 gives 3, and 2'b11 gives 1.
- R2: Bus cycle k of a transfer (k counted from 0) drives address base+k, reduced modulo 2^24, so addresses wrap from FFFFFF to 000000. Bus cycle 0 is the first cycle after the clock edge that accepts start.
- R3: On a load, the byte read in bus cycle k ends up in result bits [8k+7:8k], so the data is assembled little-endian.
- R4: On a load narrower than three bytes, the result bytes above the loaded width read as zero.
- R5: On a store, bus cycle k drives store-value byte k on dout with we high. In every cycle that is not a store bus cycle, including the cycle right after the last store byte, we is low and dout is zero.
- R6: busy is high exactly during the bus cycles. done is high for a single cycle, the one right after the last bus cycle, and busy is low in that cycle.
- R7: A start seen while busy is high is ignored. The transfer in progress keeps its addresses, direction and data.
- R8: hist shifts in each byte read by a load, with the newest byte in bits [7:0]. It therefore always holds the last three bytes loaded, across transfers. Stores leave it unchanged.
- R9: result changes only during a load. It keeps its value through stores and idle cycles until the next load starts.
- R10: After reset, busy, done, we, addr, dout, result and hist are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a transfer; only acted on while idle |
| is_store | input | 1 | 1 for store, 0 for load, sampled with start |
| width_code | input | 2 | Register width select, sampled with start |
| base_addr | input | 24 | Address of the low byte, sampled with start |
| store_val | input | 24 | Register value to store, sampled with start |
| din | input | 8 | Read data for the address currently driven |
| addr | output | 24 | Bus address |
| dout | output | 8 | Write data |
| we | output | 1 | Write strobe |
| busy | output | 1 | A bus cycle of a transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 24 | Assembled load value |
| hist | output | 24 | Last three loaded bytes, newest in [7:0] |

## Verification
A wrong remaining-byte count shows up at the ports on the next edge, as a missing or extra bus cycle and a misplaced done pulse. A wrong byte index shows in the same cycle as a wrong dout byte, or one cycle later as a result byte in the wrong lane. An address register that fails to step or to wrap repeats or skips an address in the very next bus cycle. Each of these shows within one transfer, at most four cycles after start.

// File: rtl/mbyte_xfer.sv
module mbyte_xfer #(
  parameter int ADDR_W = 24,
  parameter int NB     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_store,
  input  logic [1:0]        width_code,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [8*NB-1:0]   store_val,
  input  logic [7:0]        din,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        dout,
  output logic              we,
  output logic              busy,
  output logic              done,
  output logic [8*NB-1:0]   result,
  output logic [8*NB-1:0]   hist
);
  localparam int RW = 8 * NB;
  localparam int CW = (NB > 2) ? $clog2(NB) : 1;

  logic              busy_q, done_q, st_q;
  logic [CW-1:0]     cnt_q, idx_q, cnt_init;
  logic [ADDR_W-1:0] addr_q;
  logic [RW-1:0]     sval_q, res_q, hist_q;
  logic [7:0]        sbyte;

  assign cnt_init = (width_code == 2'd3) ? '0 : CW'(width_code);

  always_comb begin
    sbyte = '0;
    for (int b = 0; b < NB; b++)
      if (idx_q == CW'(b)) sbyte = sval_q[b*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      st_q   <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      addr_q <= '0;
      sval_q <= '0;
      res_q  <= '0;
      hist_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          st_q   <= is_store;
          addr_q <= base_addr;
          cnt_q  <= cnt_init;
          idx_q  <= '0;
          sval_q <= store_val;
          if (!is_store) res_q <= '0;
        end
      end else begin
        if (!st_q) begin
          for (int b = 0; b < NB; b++)
            if (idx_q == CW'(b)) res_q[b*8 +: 8] <= din;
          hist_q <= {hist_q[RW-9:0], din};
        end
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q  <= cnt_q - 1'b1;
          idx_q  <= idx_q + 1'b1;
          addr_q <= addr_q + 1'b1;
        end
      end
    end
  end

  assign addr   = addr_q;
  assign we     = busy_q & st_q;
  assign dout   = (busy_q & st_q) ? sbyte : 8'h00;
  assign busy   = busy_q;
  assign done   = done_q;
  assign result = res_q;
  assign hist   = hist_q;

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> addr == $past(addr) + 1'b1);
  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q < CW'(NB)) && (idx_q < CW'(NB)));
  p_we_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> busy);
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));
  p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && $past(busy)) |-> $stable(st_q) && $stable(sval_q));
  p_hold_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result));
  p_store_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && we) |=> $stable(result) && $stable(hist));
endmodule

// File: tb/tb_mbyte_xfer.sv
module tb_mbyte_xfer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        is_store = 1'b0;
  logic [1:0]  width_code = 2'd0;
  logic [23:0] base_addr = '0;
  logic [23:0] store_val = '0;
  logic [7:0]  din;
  logic [23:0] addr, result, hist;
  logic [7:0]  dout;
  logic        we, busy, done;

  int nvec = 0;
  int nerr = 0;
  logic [23:0] m_res = '0;
  logic [23:0] m_hist = '0;

  always #2 clk = ~clk;

  function automatic logic [7:0] memf(input logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h5A;
  endfunction

  function automatic int nbytes(input logic [1:0] c);
    return (c == 2'd3) ? 1 : int'(c) + 1;
  endfunction

  assign din = memf(addr);

  mbyte_xfer dut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_store(is_store),
    .width_code(width_code), .base_addr(base_addr), .store_val(store_val),
    .din(din), .addr(addr), .dout(dout), .we(we), .busy(busy), .done(done),
    .result(result), .hist(hist));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit st, input logic [1:0] code, input logic [23:0] base,
                      input logic [23:0] val, input bit hold);
    int n;
    logic [23:0] a;
    n = nbytes(code);
    @(negedge clk);
    start = 1'b1; is_store = st; width_code = code; base_addr = base; store_val = val;
    if (!st) m_res = '0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (hold) begin
        start = 1'b1; is_store = ~st; width_code = 2'd2;
        base_addr = $urandom; store_val = $urandom;
      end else start = 1'b0;
      a = base + 24'(k);
      chk(busy === 1'b1, "R6 busy in bus cycle", {31'd0, busy}, 1);
      chk(done === 1'b0, "R6 done low in bus cycle", {31'd0, done}, 0);
      chk(addr === a, "R2 address", {8'd0, addr}, {8'd0, a});
      if (st) begin
        chk(we === 1'b1, "R5 we on store byte", {31'd0, we}, 1);
        chk(dout === val[8*k +: 8], "R5 store byte order", {24'd0, dout}, {24'd0, val[8*k +: 8]});
      end else begin
        chk(we === 1'b0, "R5 we low on load", {31'd0, we}, 0);
        m_res[8*k +: 8] = memf(a);
        m_hist = {m_hist[15:0], memf(a)};
      end
    end
    @(negedge clk);
    start = 1'b0;
    chk(done === 1'b1 && busy === 1'b0, "R6 done pulse after last byte (R1 count)",
        {30'd0, done, busy}, 32'h2);
    chk(we === 1'b0 && dout === 8'h00, "R5 we low after store", {23'd0, we, dout}, 0);
    chk(result === m_res, "R3 R4 R9 result", {8'd0, result}, {8'd0, m_res});
    chk(hist === m_hist, "R8 history", {8'd0, hist}, {8'd0, m_hist});
    @(negedge clk);
    chk(done === 1'b0, "R6 done single cycle", {31'd0, done}, 0);
    chk(result === m_res, "R9 result held", {8'd0, result}, {8'd0, m_res});
  endtask

  initial begin
    #400000;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk({busy, done, we} === 3'b000, "R10 reset controls", {29'd0, busy, done, we}, 0);
    chk(addr === 24'd0 && dout === 8'd0, "R10 reset bus", {addr, dout}, 0);
    chk(result === 24'd0 && hist === 24'd0, "R10 reset regs", {8'd0, result ^ hist}, 0);
    rst_n = 1'b1;
    xfer(1'b0, 2'd0, 24'h000010, 24'h0, 1'b0);
    xfer(1'b0, 2'd1, 24'h001200, 24'h0, 1'b0);
    xfer(1'b0, 2'd2, 24'hF00000, 24'h0, 1'b0);
    xfer(1'b0, 2'd3, 24'h000123, 24'h0, 1'b0);
    xfer(1'b0, 2'd2, 24'hFFFFFF, 24'h0, 1'b0);
    xfer(1'b0, 2'd1, 24'hFFFFFF, 24'h0, 1'b0);
    xfer(1'b1, 2'd2, 24'hFFFFFE, 24'h123456, 1'b0);
    xfer(1'b1, 2'd1, 24'h000200, 24'hABCDEF, 1'b0);
    xfer(1'b1, 2'd3, 24'h000300, 24'h77AA55, 1'b0);
    xfer(1'b0, 2'd2, 24'h004000, 24'h0, 1'b1);
    xfer(1'b1, 2'd2, 24'h005000, 24'hC0FFEE, 1'b1);
    for (int i = 0; i < 400; i++)
      xfer(1'($urandom), 2'($urandom), 24'($urandom), 24'($urandom), 1'($urandom));
    repeat (2) @(negedge clk);
    chk(result === m_res, "R9 result idle", {8'd0, result}, {8'd0, m_res});
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule